// File: doc/BRIEF.md
# Supply Window Qualifier Sequencer

This block decides when a board supply may be passed to the load. It takes four digital comparator results from an external monitor: two around the lower edge of the allowed window and two around the upper edge, so that each edge has a trip level and a release level. It also takes a flag that reports the internal supply is too low to run, and a timebase tick. From these it drives a gate-enable signal to the current controller, and three status flags.

From the idle state the supply must first rise past the lower release level while staying under the upper release level. It must then stay inside the window for a fixed number of ticks before the gate turns on. Once the gate is on, a trip on either edge must last for the same number of ticks before the gate turns off. A level that crosses back before that count completes is forgotten. After a trip, the gate comes back as soon as the level crosses the release level of the edge that tripped. There is no filter and no new start-up delay on this path. Pulling the monitor below the lower trip level therefore acts as a filtered external disable. The delay and the filter share one tick count and one timebase, so they always scale together.

Top module: `supply_window_seq`

## Requirements
- R1: Out of reset the block sits in the idle state: gate_en, delay_busy, uv_tripped and ov_tripped are all 0.
- R2: In the idle state with lockout low, a cycle with uv_hi=1 and ov_lo=1 (inside the window) moves the block to the start-up delay on the next cycle, with delay_busy=1.
- R3: During the start-up delay, each cycle with tick=1 adds one to the count. If neither trip input is set, gate_en becomes 1 on the cycle after the DLY_TICKS-th tick.
- R4: If uv_lo=1 or ov_hi=1 during the start-up delay, the block returns to idle on the next cycle. A later entry starts the count from zero.
- R5: While gate_en=1, a trip input (uv_lo or ov_hi) held through DLY_TICKS ticks turns gate_en off on the next cycle. It then sets uv_tripped if uv_lo was set on that tick, and ov_tripped otherwise, so uv_lo has priority.
- R6: While the gate is on, any cycle with neither trip input set clears the filter count, so a later trip needs a full DLY_TICKS ticks again.
- R7: In the undervoltage-tripped state, a cycle with uv_hi=1 and ov_hi=0 turns gate_en back on in the next cycle, without waiting for any tick.
- R8: In the overvoltage-tripped state, a cycle with ov_lo=1 and uv_lo=0 turns gate_en back on in the next cycle, without waiting for any tick.
- R9: lockout=1 forces gate_en to 0 in the same cycle and returns the block to idle. Powering the load again then needs a full start-up delay.
- R10: Levels inside a hysteresis band do not change the state. In the on state, uv_lo=0 with uv_hi=0, or ov_hi=0 with ov_lo=0, keeps the gate on. In a tripped state, a level that has not reached the release level of that edge keeps the gate off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lockout | input | 1 | Internal supply below its operating level |
| tick | input | 1 | Timebase strobe, one cycle wide |
| uv_lo | input | 1 | Level below the lower trip threshold |
| uv_hi | input | 1 | Level above the lower release threshold |
| ov_hi | input | 1 | Level above the upper trip threshold |
| ov_lo | input | 1 | Level below the upper release threshold |
| gate_en | output | 1 | Enable to the load current controller |
| delay_busy | output | 1 | Start-up delay in progress |
| uv_tripped | output | 1 | Gate held off by a filtered undervoltage trip |
| ov_tripped | output | 1 | Gate held off by a filtered overvoltage trip |

## Verification
The assertions watch several rules on every cycle. The four output flags are never set together. Lockout always leaves the block idle, and an abort during the delay always lands in idle. The gate only turns on from the delay or a tripped state, and it only turns off on a tick or under lockout. Each release condition brings the gate back on the next cycle. The exact tick count of the delay and the filter, the reset of the filter on a return, hysteresis-band stability and the uv_lo priority can only be shown by the bench. It runs directed sequences and a random level walk against a cycle-level model of the requirements.

// File: rtl/swq_pkg.sv
package swq_pkg;
   typedef enum logic [2:0] {
      SW_IDLE = 3'd0,
      SW_WAIT = 3'd1,
      SW_ON   = 3'd2,
      SW_UVT  = 3'd3,
      SW_OVT  = 3'd4
   } swq_state_e;
endpackage

// File: rtl/swq_insync.sv
module swq_insync #(
   parameter int W      = 6,
   parameter int STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("swq_insync: W must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_s
      $error("swq_insync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_pipe
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/swq_tick_counter.sv
module swq_tick_counter #(
   parameter int TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic done
);
   localparam int CNT_W = $clog2(TICKS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

   if (TICKS < 1) begin : g_bad_t
      $error("swq_tick_counter: TICKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   assign done = run && tick && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || done)   cnt <= '0;
      else if (tick)           cnt <= cnt + 1'b1;
   end

   // R6: count never passes the terminal value
   a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   // R6: an idle cycle leaves the count at zero
   a_r6_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
endmodule

// File: rtl/supply_window_seq.sv
module supply_window_seq
   import swq_pkg::*;
#(
   parameter int DLY_TICKS = 16,
   parameter int IN_SYNC   = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lockout,
   input  logic tick,
   input  logic uv_lo,
   input  logic uv_hi,
   input  logic ov_hi,
   input  logic ov_lo,
   output logic gate_en,
   output logic delay_busy,
   output logic uv_tripped,
   output logic ov_tripped
);
   localparam int NIN = 6;

   if (DLY_TICKS < 1) begin : g_bad_dly
      $error("supply_window_seq: DLY_TICKS must be at least 1");
   end

   logic [NIN-1:0] raw_in, syn_in;
   logic s_lock, s_tick, s_uvlo, s_uvhi, s_ovhi, s_ovlo;

   assign raw_in = {lockout, tick, uv_lo, uv_hi, ov_hi, ov_lo};

   swq_insync #(.W(NIN), .STAGES(IN_SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign {s_lock, s_tick, s_uvlo, s_uvhi, s_ovhi, s_ovlo} = syn_in;

   swq_state_e st, st_nxt;
   logic in_win, trip, run, done;

   assign in_win = s_uvhi && s_ovlo;
   assign trip   = s_uvlo || s_ovhi;
   assign run    = !s_lock && (((st == SW_WAIT) && !trip) || ((st == SW_ON) && trip));

   swq_tick_counter #(.TICKS(DLY_TICKS)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (s_tick),
      .done  (done)
   );

   always_comb begin
      st_nxt = st;
      if (s_lock) begin
         st_nxt = SW_IDLE;
      end else begin
         unique case (st)
            SW_IDLE: if (in_win) st_nxt = SW_WAIT;
            SW_WAIT: begin
               if (trip)      st_nxt = SW_IDLE;
               else if (done) st_nxt = SW_ON;
            end
            SW_ON:   if (done) st_nxt = s_uvlo ? SW_UVT : SW_OVT;
            SW_UVT:  if (s_uvhi && !s_ovhi) st_nxt = SW_ON;
            SW_OVT:  if (s_ovlo && !s_uvlo) st_nxt = SW_ON;
            default: st_nxt = SW_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= SW_IDLE;
      else        st <= st_nxt;
   end

   assign gate_en    = (st == SW_ON) && !s_lock;
   assign delay_busy = (st == SW_WAIT);
   assign uv_tripped = (st == SW_UVT);
   assign ov_tripped = (st == SW_OVT);

   // R1: at most one status flag at a time
   a_r1_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gate_en, delay_busy, uv_tripped, ov_tripped}));
   // R9: lockout leaves the block idle on the following cycle
   a_r9_lockout_idle: assert property (@(posedge clk) disable iff (!rst_n)
      s_lock |=> (!gate_en && !delay_busy && !uv_tripped && !ov_tripped));
   // R4: a trip during the delay aborts to idle
   a_r4_delay_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (delay_busy && trip && !s_lock) |=> (!delay_busy && !gate_en));
   // R3: gate only turns on from the delay or a tripped state
   a_r3_gate_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en) |-> $past(delay_busy || uv_tripped || ov_tripped));
   // R5: gate only drops on a tick unless lockout acts
   a_r5_drop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate_en) && !s_lock) |-> $past(s_tick || s_lock));
   // R7: undervoltage release restores the gate next cycle
   a_r7_uv_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_tripped && s_uvhi && !s_ovhi && !s_lock) |=> (gate_en || s_lock));
   // R8: overvoltage release restores the gate next cycle
   a_r8_ov_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_tripped && s_ovlo && !s_uvlo && !s_lock) |=> (gate_en || s_lock));
endmodule

// File: tb/tb_supply_window_seq.sv
module tb_supply_window_seq;
   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lockout = 1'b0, tick = 1'b0;
   logic uv_lo, uv_hi, ov_hi, ov_lo;
   logic gate_en, delay_busy, uv_tripped, ov_tripped;

   int band = 0;
   int m_st = 0;
   int m_cnt = 0;
   int n_chk = 0;
   int n_bad = 0;
   int wd = 0;
   bit fin = 0;

   always #5 clk = ~clk;

   // band 0: below lower trip, 1: lower hysteresis, 2: window,
   // 3: upper hysteresis, 4: above upper trip
   function automatic logic [3:0] cmp_of(input int b);
      return {b == 0, b >= 2, b == 4, b <= 2};
   endfunction

   assign {uv_lo, uv_hi, ov_hi, ov_lo} = cmp_of(band);

   supply_window_seq #(.DLY_TICKS(N), .IN_SYNC(0)) dut (
      .clk(clk), .rst_n(rst_n), .lockout(lockout), .tick(tick),
      .uv_lo(uv_lo), .uv_hi(uv_hi), .ov_hi(ov_hi), .ov_lo(ov_lo),
      .gate_en(gate_en), .delay_busy(delay_busy),
      .uv_tripped(uv_tripped), .ov_tripped(ov_tripped)
   );

   // reference: 0 idle, 1 delay, 2 on, 3 uv tripped, 4 ov tripped
   function automatic void model_step(input int st, input int cnt, input int b,
                                      input bit tk, input bit lk,
                                      output int nst, output int ncnt);
      logic [3:0] c;
      bit lo, hi, oh, ol, flt;
      c = cmp_of(b);
      {lo, hi, oh, ol} = c;
      flt = lo || oh;
      nst = st; ncnt = cnt;
      if (lk) begin nst = 0; ncnt = 0; return; end
      case (st)
         0: begin ncnt = 0; if (hi && ol) nst = 1; end
         1: if (flt) begin nst = 0; ncnt = 0; end
            else if (tk) begin
               if (cnt + 1 == N) begin nst = 2; ncnt = 0; end else ncnt = cnt + 1;
            end
         2: if (!flt) ncnt = 0;
            else if (tk) begin
               if (cnt + 1 == N) begin nst = lo ? 3 : 4; ncnt = 0; end else ncnt = cnt + 1;
            end
         3: if (hi && !oh) nst = 2;
         default: if (ol && !lo) nst = 2;
      endcase
   endfunction

   always @(posedge clk) begin : model
      int ns, nc;
      if (!rst_n) begin
         m_st <= 0; m_cnt <= 0;
      end else begin
         model_step(m_st, m_cnt, band, tick, lockout, ns, nc);
         m_st <= ns; m_cnt <= nc;
      end
   end

   task automatic compare(input string tag);
      logic [3:0] exp, act;
      exp = {(m_st == 2) && !lockout, m_st == 1, m_st == 3, m_st == 4};
      act = {gate_en, delay_busy, uv_tripped, ov_tripped};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {gate,busy,uvt,ovt} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic cyc(input int b, input bit t, input bit l, input string tag);
      band = b; tick = t; lockout = l;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !fin) begin
         fin = 1;
         n_chk++; n_bad++;
         $display("FAIL R1: watchdog actual=running expected=finished");
         report();
      end
   end

   initial begin
      int seed, b;
      string tg;
      seed = 32'h5A17;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 0, 0, "R1");
      cyc(0, 1, 0, "R1");
      cyc(1, 1, 0, "R2");               // hysteresis band: no entry
      cyc(2, 0, 0, "R2");               // entry -> delay
      for (int i = 0; i < 3; i++) cyc(2, 1, 0, "R3");
      cyc(2, 1, 0, "R3");               // 4th tick -> on
      cyc(2, 1, 0, "R3");
      for (int i = 0; i < 6; i++) cyc(3, 1, 0, "R10");
      for (int i = 0; i < 6; i++) cyc(1, 1, 0, "R10");
      for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R6");
      cyc(2, 0, 0, "R6");               // return clears the filter
      for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R6");
      cyc(0, 0, 0, "R6");
      cyc(0, 1, 0, "R5");               // 4th consecutive tick -> uv trip
      cyc(0, 1, 0, "R5");
      for (int i = 0; i < 5; i++) cyc(1, 1, 0, "R10");
      cyc(2, 0, 0, "R7");               // release without tick
      cyc(2, 0, 0, "R7");
      for (int i = 0; i < 4; i++) cyc(4, 1, 0, "R5");
      cyc(4, 0, 0, "R5");
      for (int i = 0; i < 4; i++) cyc(3, 1, 0, "R10");
      cyc(2, 0, 0, "R8");
      cyc(2, 0, 0, "R8");
      cyc(2, 1, 1, "R9");               // gate drops same cycle
      cyc(2, 0, 0, "R9");
      cyc(2, 0, 0, "R9");
      cyc(2, 1, 0, "R4");
      cyc(2, 1, 0, "R4");
      cyc(0, 1, 0, "R4");               // abort
      cyc(2, 0, 0, "R4");
      for (int i = 0; i < 3; i++) cyc(2, 1, 0, "R4");
      cyc(2, 1, 0, "R4");
      cyc(2, 0, 0, "R3");
      // random level walk
      b = 2;
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 10 && b > 0) b--;
         else if (r < 20 && b < 4) b++;
         else if (r < 22) b = $urandom_range(0, 4);
         case (m_st)
            0: tg = "R2";
            1: tg = "R3";
            2: tg = "R5";
            3: tg = "R7";
            default: tg = "R8";
         endcase
         if ($urandom_range(0, 299) == 0) tg = "R9";
         cyc(b, $urandom_range(0, 2) == 0, tg == "R9", tg);
      end
      fin = 1;
      report();
   end
endmodule